// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block moves stereo audio samples between a parallel core-side interface and a three-wire serial link made of a bit clock, a frame clock and one data line in each direction. The receive path turns the serial input into left and right sample words and announces each completed pair with a one-cycle strobe. The transmit path takes a left/right pair loaded by a strobe and shifts it out, most significant bit first, as two's-complement data.

Four framings share one slot counter. They are 24-bit I2S, 24-bit left-justified, 24-bit right-justified and 16-bit right-justified. The selection is a static configuration input.

The port samples the bit and frame clocks with its own system clock. As a slave it takes them from the link pins and measures how many bit clocks each half-frame holds. As a master it takes them from an external clock generator, drives them onto the link and enables the pin drivers.

Top module: `aud_serial_port`

## Requirements
- R1: Receive data is sampled on rising bit-clock edges, MSB first. When the right word of a frame is complete, `rx_valid_o` pulses for exactly one cycle. At that point `rx_left_o` and `rx_right_o` carry that frame's pair, and 16-bit words are sign-extended to 24 bits.
- R2: `sdout_o` changes only while the bit clock is low, after a falling edge. It is constant for the whole high phase.
- R3: `cfg_fmt_i` selects the framing as follows.
  - 2'b00 is 24-bit I2S. The MSB comes one bit clock after the frame-clock edge, and frame clock low marks the left channel.
  - 2'b01 is 24-bit left-justified. The MSB is in the first bit clock after the edge, and frame clock high marks left.
  - 2'b10 is 24-bit right-justified and 2'b11 is 16-bit right-justified. In both, frame clock high marks left and the LSB is the last bit of each half-frame.
- R4: In slave mode the port accepts 32 or 24 bit clocks per half-frame (64 or 48 per frame). It measures the count between frame-clock edges and uses the last measured length to place right-justified words.
- R5: With `cfg_master_i`=1, the clocks come from `gen_bclk_i`/`gen_lrck_i` and are driven on `bclk_o`/`lrck_o` with `clk_oe_o`=1. The half-frame length is fixed at 32. In slave mode the clocks come from `ext_bclk_i`/`ext_lrck_i` and `clk_oe_o`=0.
- R6: During and after reset the port is a slave: `clk_oe_o`=0, `sdout_o`=0, `rx_valid_o`=0, and both received words are 0.
- R7: Transmit bit slots outside the word are sent as 0.
- R8: Received bits outside the word window do not change the received words.
- R9: A pair loaded with `tx_valid_i` is used from the next left half-frame start, and it is held for the whole frame. A pair loaded in the middle of a frame leaves that frame unchanged. In 16-bit format the low 16 bits of each transmit word are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master_i | input | 1 | 1 = clock master, 0 = slave |
| cfg_fmt_i | input | 2 | Framing select (see R3) |
| ext_bclk_i | input | 1 | Bit clock from link pin (slave) |
| ext_lrck_i | input | 1 | Frame clock from link pin (slave) |
| gen_bclk_i | input | 1 | Bit clock from clock generator (master) |
| gen_lrck_i | input | 1 | Frame clock from clock generator (master) |
| bclk_o | output | 1 | Bit clock driven to link in master mode |
| lrck_o | output | 1 | Frame clock driven to link in master mode |
| clk_oe_o | output | 1 | Output enable for the clock pins |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| tx_left_i | input | 24 | Left word to transmit |
| tx_right_i | input | 24 | Right word to transmit |
| tx_valid_i | input | 1 | Loads the transmit pair |
| rx_left_o | output | 24 | Last received left word |
| rx_right_o | output | 24 | Last received right word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
A slot counter that is one position off shows up in the first checked frame. Every transmitted bit shifts to a neighbouring slot, and the received words come out scaled by two or carry a stray bit. A wrong channel reference swaps the left and right words. A wrong measured half-frame length misplaces only right-justified words, and only from the frame after the length is measured. The bench drives three identical frames per case and compares every serial bit and both words against values computed from the framing rules.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ16 = 2'b11
  } aud_fmt_e;

  function automatic logic fmt_delayed(input aud_fmt_e f);
    return (f == FMT_I2S);
  endfunction

  function automatic logic fmt_right_aligned(input aud_fmt_e f);
    return f[1];
  endfunction

  function automatic logic fmt_short(input aud_fmt_e f);
    return (f == FMT_RJ16);
  endfunction
endpackage

// File: rtl/aud_clk_front.sv
module aud_clk_front #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master_i,
  input  logic ext_bclk_i,
  input  logic ext_lrck_i,
  input  logic gen_bclk_i,
  input  logic gen_lrck_i,
  input  logic sdin_i,
  output logic rst_ns,
  output logic master_q,
  output logic bclk_lvl,
  output logic bclk_rise,
  output logic lr_lvl,
  output logic din_lvl
);
  localparam int LINES = 3;

  logic [1:0]       rst_pipe;
  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic             bclk_prev;

  // reset: asserted asynchronously, released on clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) master_q <= 1'b0;
    else         master_q <= cfg_master_i;
  end

  // clock source selection: link pins as slave, generator as master
  always_comb begin
    raw[0] = master_q ? gen_bclk_i : ext_bclk_i;
    raw[1] = master_q ? gen_lrck_i : ext_lrck_i;
    raw[2] = sdin_i;
  end

  generate
    if (SYNC_N == 1) begin : g_sync1
      logic [LINES-1:0] stg;
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) stg <= '0;
        else         stg <= raw;
      end
      assign synced = stg;
    end else begin : g_syncn
      logic [SYNC_N-1:0][LINES-1:0] stg;
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) stg <= '0;
        else         stg <= {stg[SYNC_N-2:0], raw};
      end
      assign synced = stg[SYNC_N-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) bclk_prev <= 1'b0;
    else         bclk_prev <= synced[0];
  end

  assign bclk_lvl  = synced[0];
  assign lr_lvl    = synced[1];
  assign din_lvl   = synced[2];
  assign bclk_rise = synced[0] & ~bclk_prev;
endmodule

// File: rtl/aud_frame_track.sv
module aud_frame_track
  import aud_sp_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int SHORT_W    = 16,
  parameter int SLOT_W     = 6,
  parameter int LONG_HALF  = 32,
  parameter int SHORT_HALF = 24
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              master_q,
  input  aud_fmt_e          fmt,
  input  logic              bclk_rise,
  input  logic              lr_lvl,
  output logic [SLOT_W-1:0] nslot,
  output logic [SLOT_W-1:0] rel,
  output logic              ch_left,
  output logic              in_win,
  output logic              win_last,
  output logic              frame_start
);
  logic              lr_rise_q, ref_q, lr_eff, edge_seen, dly;
  logic              ref_d, lr_rise_d;
  logic [SLOT_W-1:0] nslot_d, half_q, half_d;
  logic [SLOT_W-1:0] wlen, wstart, wend;

  assign dly       = fmt_delayed(fmt);
  // delayed framing uses the frame clock as seen one bit earlier
  assign lr_eff    = dly ? lr_rise_q : lr_lvl;
  assign edge_seen = (lr_eff != ref_q);
  assign ch_left   = ref_q ^ dly;
  assign frame_start = edge_seen & (lr_eff ^ dly);

  assign wlen   = fmt_short(fmt) ? SLOT_W'(SHORT_W) : SLOT_W'(WORD_W);
  assign wstart = fmt_right_aligned(fmt) ? (half_q - wlen) : '0;
  assign wend   = wstart + wlen;
  assign rel    = nslot - wstart;
  assign in_win   = (nslot >= wstart) && (nslot < wend);
  assign win_last = (nslot == (wend - SLOT_W'(1)));

  always_comb begin
    ref_d     = ref_q;
    nslot_d   = nslot;
    half_d    = half_q;
    lr_rise_d = bclk_rise ? lr_lvl : lr_rise_q;
    if (edge_seen) begin
      ref_d   = lr_eff;
      nslot_d = '0;
      if (master_q)                            half_d = SLOT_W'(LONG_HALF);
      else if (nslot == SLOT_W'(SHORT_HALF))   half_d = SLOT_W'(SHORT_HALF);
      else                                     half_d = SLOT_W'(LONG_HALF);
    end else if (bclk_rise && (nslot != '1)) begin
      nslot_d = nslot + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ref_q     <= 1'b0;
      lr_rise_q <= 1'b0;
      nslot     <= '0;
      half_q    <= SLOT_W'(LONG_HALF);
    end else begin
      ref_q     <= ref_d;
      lr_rise_q <= lr_rise_d;
      nslot     <= nslot_d;
      half_q    <= half_d;
    end
  end

  p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (half_q == SLOT_W'(LONG_HALF)) || (half_q == SLOT_W'(SHORT_HALF)));

  p_master_len_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    master_q |-> (half_q == SLOT_W'(LONG_HALF)));

  p_frame_start_left_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    frame_start |=> ch_left);
endmodule

// File: rtl/aud_rx_path.sv
module aud_rx_path
  import aud_sp_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  aud_fmt_e          fmt,
  input  logic              bclk_rise,
  input  logic              din_lvl,
  input  logic              ch_left,
  input  logic              in_win,
  input  logic              win_last,
  output logic [WORD_W-1:0] rx_left_o,
  output logic [WORD_W-1:0] rx_right_o,
  output logic              rx_valid_o
);
  localparam int EXT_W = WORD_W - SHORT_W;

  logic [WORD_W-1:0] sh_q, sh_d, hold_q, hold_d, full, word;
  logic [WORD_W-1:0] l_d, r_d;
  logic              valid_d;

  assign full = {sh_q[WORD_W-2:0], din_lvl};
  assign word = fmt_short(fmt) ? {{EXT_W{full[SHORT_W-1]}}, full[SHORT_W-1:0]} : full;

  always_comb begin
    sh_d    = sh_q;
    hold_d  = hold_q;
    l_d     = rx_left_o;
    r_d     = rx_right_o;
    valid_d = 1'b0;
    if (bclk_rise && in_win) begin
      sh_d = full;
      if (win_last) begin
        if (ch_left) begin
          hold_d = word;
        end else begin
          l_d     = hold_q;
          r_d     = word;
          valid_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sh_q       <= '0;
      hold_q     <= '0;
      rx_left_o  <= '0;
      rx_right_o <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      sh_q       <= sh_d;
      hold_q     <= hold_d;
      rx_left_o  <= l_d;
      rx_right_o <= r_d;
      rx_valid_o <= valid_d;
    end
  end

  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/aud_tx_path.sv
module aud_tx_path
  import aud_sp_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16,
  parameter int SLOT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  aud_fmt_e          fmt,
  input  logic              bclk_lvl,
  input  logic              frame_start,
  input  logic              ch_left,
  input  logic              in_win,
  input  logic [SLOT_W-1:0] rel,
  input  logic [WORD_W-1:0] tx_left_i,
  input  logic [WORD_W-1:0] tx_right_i,
  input  logic              tx_valid_i,
  output logic              sdout_o
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] pend_l_q, pend_r_q, act_l_q, act_r_q;
  logic [WORD_W-1:0] pend_l_d, pend_r_d, act_l_d, act_r_d, cur;
  logic [IDX_W-1:0]  top, idx;
  logic              bit_nx, dout_d;

  assign top = fmt_short(fmt) ? IDX_W'(SHORT_W - 1) : IDX_W'(WORD_W - 1);
  assign idx = top - rel[IDX_W-1:0];
  assign cur = ch_left ? act_l_q : act_r_q;
  assign bit_nx = in_win ? cur[idx] : 1'b0;

  always_comb begin
    pend_l_d = tx_valid_i ? tx_left_i  : pend_l_q;
    pend_r_d = tx_valid_i ? tx_right_i : pend_r_q;
    act_l_d  = frame_start ? pend_l_d : act_l_q;
    act_r_d  = frame_start ? pend_r_d : act_r_q;
    // new bit only while the bit clock is low
    dout_d   = bclk_lvl ? sdout_o : bit_nx;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      act_l_q  <= '0;
      act_r_q  <= '0;
      sdout_o  <= 1'b0;
    end else begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      act_l_q  <= act_l_d;
      act_r_q  <= act_r_d;
      sdout_o  <= dout_d;
    end
  end
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_sp_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int SHORT_W    = 16,
  parameter int LONG_HALF  = 32,
  parameter int SHORT_HALF = 24,
  parameter int SYNC_N     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master_i,
  input  logic [1:0]        cfg_fmt_i,
  input  logic              ext_bclk_i,
  input  logic              ext_lrck_i,
  input  logic              gen_bclk_i,
  input  logic              gen_lrck_i,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              clk_oe_o,
  input  logic              sdin_i,
  output logic              sdout_o,
  input  logic [WORD_W-1:0] tx_left_i,
  input  logic [WORD_W-1:0] tx_right_i,
  input  logic              tx_valid_i,
  output logic [WORD_W-1:0] rx_left_o,
  output logic [WORD_W-1:0] rx_right_o,
  output logic              rx_valid_o
);
  localparam int SLOT_W = $clog2(LONG_HALF) + 1;

  aud_fmt_e          fmt;
  logic              rst_ns, master_q, bclk_lvl, bclk_rise, lr_lvl, din_lvl;
  logic [SLOT_W-1:0] nslot, rel;
  logic              ch_left, in_win, win_last, frame_start;

  assign fmt      = aud_fmt_e'(cfg_fmt_i);
  assign clk_oe_o = master_q;
  assign bclk_o   = master_q & gen_bclk_i;
  assign lrck_o   = master_q & gen_lrck_i;

  aud_clk_front #(.SYNC_N(SYNC_N)) front_i (
    .clk(clk), .rst_n(rst_n), .cfg_master_i(cfg_master_i),
    .ext_bclk_i(ext_bclk_i), .ext_lrck_i(ext_lrck_i),
    .gen_bclk_i(gen_bclk_i), .gen_lrck_i(gen_lrck_i), .sdin_i(sdin_i),
    .rst_ns(rst_ns), .master_q(master_q), .bclk_lvl(bclk_lvl),
    .bclk_rise(bclk_rise), .lr_lvl(lr_lvl), .din_lvl(din_lvl)
  );

  aud_frame_track #(
    .WORD_W(WORD_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W),
    .LONG_HALF(LONG_HALF), .SHORT_HALF(SHORT_HALF)
  ) track_i (
    .clk(clk), .rst_ns(rst_ns), .master_q(master_q), .fmt(fmt),
    .bclk_rise(bclk_rise), .lr_lvl(lr_lvl), .nslot(nslot), .rel(rel),
    .ch_left(ch_left), .in_win(in_win), .win_last(win_last),
    .frame_start(frame_start)
  );

  aud_rx_path #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) rx_i (
    .clk(clk), .rst_ns(rst_ns), .fmt(fmt), .bclk_rise(bclk_rise),
    .din_lvl(din_lvl), .ch_left(ch_left), .in_win(in_win),
    .win_last(win_last), .rx_left_o(rx_left_o), .rx_right_o(rx_right_o),
    .rx_valid_o(rx_valid_o)
  );

  aud_tx_path #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W)) tx_i (
    .clk(clk), .rst_ns(rst_ns), .fmt(fmt), .bclk_lvl(bclk_lvl),
    .frame_start(frame_start), .ch_left(ch_left), .in_win(in_win),
    .rel(rel), .tx_left_i(tx_left_i), .tx_right_i(tx_right_i),
    .tx_valid_i(tx_valid_i), .sdout_o(sdout_o)
  );

  p_tx_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (bclk_lvl && $past(bclk_lvl)) |-> $stable(sdout_o));
endmodule

// File: tb/aud_serial_port_tb_top.sv
module aud_serial_port_tb_top;
  localparam int HP = 6;
  localparam int NV = 10;
  // {master, fmt[1:0], half32, rx_l, rx_r, tx_l, tx_r}
  localparam logic [99:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b1, 24'hA5C3E1, 24'h1E2D3C, 24'h80F00F, 24'h7FFFFE},
    {1'b0, 2'd0, 1'b0, 24'h123456, 24'hFEDCBA, 24'hC0FFEE, 24'h0BADF0},
    {1'b0, 2'd1, 1'b1, 24'h800001, 24'h7F0F0F, 24'h5A5A5A, 24'hA5A5A5},
    {1'b0, 2'd1, 1'b0, 24'h3C3C3C, 24'hC3C3C3, 24'h010203, 24'hF0E0D0},
    {1'b0, 2'd2, 1'b1, 24'hDEADBE, 24'h00FF00, 24'h9ABCDE, 24'h135790},
    {1'b0, 2'd3, 1'b1, 24'h00ABCD, 24'h001234, 24'hFF8001, 24'h007FFE},
    {1'b0, 2'd3, 1'b0, 24'h008123, 24'h007ABC, 24'h00F00F, 24'h000FF0},
    {1'b1, 2'd1, 1'b1, 24'h654321, 24'h89ABCD, 24'h2468AC, 24'hECA864},
    {1'b1, 2'd3, 1'b1, 24'h00FFFF, 24'h000001, 24'h00A55A, 24'h005AA5},
    {1'b1, 2'd0, 1'b1, 24'h7E7E7E, 24'h818181, 24'h336699, 24'hCC9966}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_master, ext_bclk, ext_lrck, gen_bclk, gen_lrck;
  logic [1:0]  cfg_fmt;
  logic        bclk_o, lrck_o, clk_oe_o, sdin, sdout, tx_valid, rx_valid;
  logic [23:0] tx_l, tx_r, rx_l, rx_r;

  aud_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master_i(cfg_master), .cfg_fmt_i(cfg_fmt),
    .ext_bclk_i(ext_bclk), .ext_lrck_i(ext_lrck),
    .gen_bclk_i(gen_bclk), .gen_lrck_i(gen_lrck),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .clk_oe_o(clk_oe_o),
    .sdin_i(sdin), .sdout_o(sdout),
    .tx_left_i(tx_l), .tx_right_i(tx_r), .tx_valid_i(tx_valid),
    .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_valid)
  );

  int n_chk = 0, n_bad = 0, cap_n = 0;
  logic [23:0] cap_l, cap_r;
  // bench stimulus state
  logic [1:0]  b_fmt;
  logic        b_master;
  int          b_h, ld_p;
  logic [23:0] b_rxl, b_rxr, b_txl, b_txr, ld_l, ld_r;

  always @(negedge clk) if (rx_valid) begin
    cap_l = rx_l; cap_r = rx_r; cap_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wlen(input logic [1:0] f);
    return (f == 2'd3) ? 16 : 24;
  endfunction

  function automatic int wstart(input logic [1:0] f, input int h);
    return f[1] ? h - wlen(f) : 0;
  endfunction

  // slot value: word bit inside window, 'fill' outside (R3, R7, R8)
  function automatic logic slot_bit(input logic [23:0] w, input logic [1:0] f,
                                    input int h, input int s, input logic fill);
    int s0 = wstart(f, h);
    if (s >= s0 && s < s0 + wlen(f)) return w[wlen(f) - 1 - (s - s0)];
    return fill;
  endfunction

  function automatic logic lr_level(input logic [1:0] f, input bit left);
    return (f == 2'd0) ? !left : left;
  endfunction

  function automatic logic [23:0] rx_exp(input logic [23:0] w, input logic [1:0] f);
    return (f == 2'd3) ? {{8{w[15]}}, w[15:0]} : w;
  endfunction

  task automatic drive(input logic b, input logic l);
    if (b_master) begin gen_bclk = b; gen_lrck = l; ext_bclk = 1'b0; ext_lrck = 1'b0; end
    else          begin ext_bclk = b; ext_lrck = l; gen_bclk = 1'b0; gen_lrck = 1'b0; end
  endtask

  task automatic run_frame(input bit check, input string tag);
    int  errs = 0, unstable = 0;
    logic s1, s2, e, lr;
    bit  left;
    for (int p = 0; p < 2 * b_h; p++) begin
      left = (p < b_h);
      lr = (b_fmt == 2'd0) ? lr_level(b_fmt, ((p + 1) % (2 * b_h)) < b_h)
                           : lr_level(b_fmt, left);
      e = slot_bit(left ? b_txl : b_txr, b_fmt, b_h, p % b_h, 1'b0);
      @(negedge clk);
      drive(1'b0, lr);
      sdin = slot_bit(left ? b_rxl : b_rxr, b_fmt, b_h, p % b_h, 1'b1);
      if (p == ld_p) begin tx_l = ld_l; tx_r = ld_r; tx_valid = 1'b1; end
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (HP - 1) @(negedge clk);
      drive(1'b1, lr);
      repeat (3) @(negedge clk);
      s1 = sdout;
      repeat (HP - 4) @(negedge clk);
      s2 = sdout;
      if (s1 !== e) errs++;
      if (s2 !== s1) unstable++;
    end
    if (check) begin
      chk(errs == 0, {"R3/R7 serial out bits ", tag}, errs, 0);
      chk(unstable == 0, {"R2 out steady in high phase ", tag}, unstable, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_master = 1'b1; cfg_fmt = 2'd1; tx_valid = 1'b0;
    tx_l = '0; tx_r = '0; sdin = 1'b0; b_master = 1'b1;
    drive(1'b0, 1'b0);
    ld_p = -1; ld_l = '0; ld_r = '0;
    repeat (4) @(negedge clk);
    // R6: reset state, even with master requested
    chk(clk_oe_o == 1'b0, "R6 pins input in reset", clk_oe_o, 0);
    chk(sdout == 1'b0 && rx_valid == 1'b0, "R6 outputs idle in reset", {sdout, rx_valid}, 0);
    chk(rx_l == '0 && rx_r == '0, "R6 rx words clear in reset", rx_l ^ rx_r, 0);
    cfg_master = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(clk_oe_o == 1'b0, "R6 slave default after reset", clk_oe_o, 0);

    // table walk: R1 R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      b_master = VEC[v][99]; b_fmt = VEC[v][98:97];
      b_h = VEC[v][96] ? 32 : 24;
      b_rxl = VEC[v][95:72]; b_rxr = VEC[v][71:48];
      b_txl = VEC[v][47:24]; b_txr = VEC[v][23:0];
      cfg_master = b_master; cfg_fmt = b_fmt;
      drive(1'b0, 1'b0);
      do_reset();
      ld_p = b_h + 2; ld_l = b_txl; ld_r = b_txr;
      cap_n = 0;
      run_frame(1'b0, "");
      run_frame(1'b1, $sformatf("vec%0d", v));
      run_frame(1'b0, "");
      chk(cap_n > 0, "R1 rx strobe seen", cap_n, 1);
      chk(cap_l == rx_exp(b_rxl, b_fmt), "R1/R8 rx left word", cap_l, rx_exp(b_rxl, b_fmt));
      chk(cap_r == rx_exp(b_rxr, b_fmt), "R1/R8 rx right word", cap_r, rx_exp(b_rxr, b_fmt));
      if (b_master) begin
        chk(clk_oe_o == 1'b1, "R5 master drives clock pins", clk_oe_o, 1);
        chk(bclk_o == gen_bclk && lrck_o == gen_lrck, "R5 generator clocks forwarded",
            {bclk_o, lrck_o}, {gen_bclk, gen_lrck});
      end else begin
        chk(clk_oe_o == 1'b0, "R5 slave keeps pins as inputs", clk_oe_o, 0);
      end
    end

    // R9: pair loaded mid-frame does not disturb the current frame
    b_master = 1'b0; b_fmt = 2'd1; b_h = 32;
    cfg_master = 1'b0; cfg_fmt = 2'd1;
    b_rxl = 24'h111111; b_rxr = 24'h222222;
    b_txl = 24'hABCDEF; b_txr = 24'h13579B;
    drive(1'b0, 1'b0);
    do_reset();
    ld_p = b_h + 2; ld_l = b_txl; ld_r = b_txr;
    run_frame(1'b0, "");
    ld_p = 3; ld_l = 24'h0F1E2D; ld_r = 24'hE1D2C3;
    run_frame(1'b1, "R9 old pair held");
    b_txl = 24'h0F1E2D; b_txr = 24'hE1D2C3; ld_p = -1;
    run_frame(1'b1, "R9 new pair next frame");

    // R9: 16-bit format sends only the low half of each word
    b_fmt = 2'd3; cfg_fmt = 2'd3;
    b_txl = 24'h5A8001; b_txr = 24'hC3FFFE;
    do_reset();
    ld_p = b_h + 2; ld_l = b_txl; ld_r = b_txr;
    run_frame(1'b0, "");
    run_frame(1'b1, "R9 low 16 bits sent");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule